// File: doc/BRIEF.md
# Inclusive L2 Alias Resolver

This controller keeps a virtually-indexed L1 data cache free of synonyms. The L1 is larger per way than a page, so a few bits of its index come from the virtual page number. Two virtual addresses that map to one physical line can therefore land in different L1 sets. The resolver sits beside a direct-mapped, physically-addressed L2 that includes every L1 line. Each L2 entry records the physical tag and also the extra virtual-index bits under which its line currently lives in L1.

On every L1 miss, after translation, the requester presents the physical line address and the extra virtual-index bits used for the L1 lookup. There are four outcomes:
- **L2 hit, recorded bits equal:** a plain L1 fill.
- **L2 hit, recorded bits differ:** an alias. The old L1 copy is purged, the recorded bits are updated, and then the line is filled at the new index.
- **L2 miss on an occupied entry:** the victim is purged from L1 first, which keeps inclusion.
- **L2 miss on an empty entry:** the entry is recorded and the line is filled.

Purge and fill commands leave on a valid/ready channel toward the L1. A one-cycle completion pulse answers the miss once every command it needed has been accepted. Data arrays are not part of this block.

Top module: `alias_resolver`

## Requirements
- R1: After reset every L2 entry is empty, `reqReady` is 1, and `cmdValid` and `doneValid` are 0.
- R2: A request whose L2 entry is empty produces exactly one command. That command is a fill (`cmdKind`=0) carrying the request's line address and virtual-index bits. It is followed by a completion with `doneAlias`=0.
- R3: A request that hits in L2 with equal recorded virtual-index bits produces exactly one fill and no purge, with `doneAlias`=0.
- R4: A request that hits in L2 with different recorded bits produces two commands in order. The first is a purge (`cmdKind`=1) with the same line address and the old recorded bits. The second is a fill with the new bits. The completion then carries `doneAlias`=1.
- R5: After an alias is resolved, the recorded bits equal the new ones, so a repeat request with those bits produces only a fill.
- R6: A request that misses in L2 on an occupied entry first purges the victim, then fills the new line. The L2 set is the low `L2_SET_W` bits of the line address and the tag is the remaining upper bits. The victim purge carries the victim's line address (its tag above the same set bits) and its recorded bits.
- R7: A command held with `cmdReady` low keeps its kind, line and bits unchanged. A fill follows an accepted purge in the next cycle. `doneValid` pulses for one cycle, only in the cycle after the fill is accepted.
- R8: `reqReady` is 1 only when idle. It falls after a request is accepted and stays low until the completion pulse has passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | L1 miss request present |
| reqReady | output | 1 | Resolver idle and accepting a request |
| reqLine | input | LINE_W | Physical line address of the miss |
| reqVidx | input | VIDX_W | Virtual-index bits above the page offset used by the L1 lookup |
| cmdValid | output | 1 | Command toward L1 is valid |
| cmdReady | input | 1 | L1 accepts the command |
| cmdKind | output | 1 | 0 = fill, 1 = purge |
| cmdLine | output | LINE_W | Physical line address of the command |
| cmdVidx | output | VIDX_W | Virtual-index bits that select the L1 set |
| doneValid | output | 1 | One-cycle completion of the current miss |
| doneAlias | output | 1 | The completed miss resolved an alias |

## Verification
The assertions assume that a request is presented only while `reqReady` is high, and that the requester never changes the recorded mapping outside this block. They also assume that `cmdReady` may stall for any number of cycles but is eventually given. The stimulus keeps within these limits. It raises `reqValid` only in the idle cycle, waits for the completion pulse before the next request, and drives `cmdReady` from a random coin each cycle. Line addresses are drawn from a small pool of tags, so hits, aliases and evictions all occur often.

// File: rtl/ar_pkg.sv
package ar_pkg;
  typedef enum logic {CMD_FILL = 1'b0, CMD_PURGE = 1'b1} cmdKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latchReq;
    logic writeLine;
    logic selOld;
    logic issueFill;
  } arStrobe_t;

  // lookup status from datapath to control
  typedef struct packed {
    logic lineValid;
    logic tagHit;
    logic vidxSame;
  } arStatus_t;
endpackage

// File: rtl/ar_datapath.sv
module ar_datapath import ar_pkg::*; #(
  parameter int LINE_W = 10,
  parameter int SET_W  = 3,
  parameter int VIDX_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  arStrobe_t         strobe,
  input  logic [LINE_W-1:0] reqLine,
  input  logic [VIDX_W-1:0] reqVidx,
  output arStatus_t         status,
  output logic [LINE_W-1:0] cmdLine,
  output logic [VIDX_W-1:0] cmdVidx
);
  localparam int TAG_W = LINE_W - SET_W;
  localparam int SETS  = 1 << SET_W;

  logic [LINE_W-1:0] curLine;
  logic [VIDX_W-1:0] curVidx;
  logic [SETS-1:0]   entryValid;
  logic [TAG_W-1:0]  entryTag  [SETS];
  logic [VIDX_W-1:0] entryVidx [SETS];

  logic [SET_W-1:0] curSet;
  logic [TAG_W-1:0] curTag;
  assign curSet = curLine[SET_W-1:0];
  assign curTag = curLine[LINE_W-1:SET_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curLine <= '0;
      curVidx <= '0;
    end else if (strobe.latchReq) begin
      curLine <= reqLine;
      curVidx <= reqVidx;
    end
  end

  // one register slice per L2 entry
  for (genvar s = 0; s < SETS; s++) begin : gEntry
    always_ff @(posedge clk) begin
      if (!rstN) begin
        entryValid[s] <= 1'b0;
        entryTag[s]   <= '0;
        entryVidx[s]  <= '0;
      end else if (strobe.writeLine && curSet == SET_W'(s)) begin
        entryValid[s] <= 1'b1;
        entryTag[s]   <= curTag;
        entryVidx[s]  <= curVidx;
      end
    end
  end

  always_comb begin
    status.lineValid = entryValid[curSet];
    status.tagHit    = entryValid[curSet] && (entryTag[curSet] == curTag);
    status.vidxSame  = (entryVidx[curSet] == curVidx);
  end

  assign cmdLine = strobe.selOld ? {entryTag[curSet], curSet} : curLine;
  assign cmdVidx = strobe.selOld ? entryVidx[curSet] : curVidx;

  // R5: a fill goes out only once the entry records the new mapping
  p_fill_recorded_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.issueFill |-> entryValid[curSet] && entryTag[curSet] == curTag
                         && entryVidx[curSet] == curVidx);

  // R4: purging the requested line itself means an alias with differing bits
  p_alias_diff_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.selOld && entryTag[curSet] == curTag) |-> entryVidx[curSet] != curVidx);
endmodule

// File: rtl/ar_control.sv
module ar_control import ar_pkg::*; (
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  output logic      reqReady,
  input  arStatus_t status,
  output arStrobe_t strobe,
  output logic      cmdValid,
  input  logic      cmdReady,
  output cmdKind_e  cmdKind,
  output logic      doneValid,
  output logic      doneAlias
);
  typedef enum logic [2:0] {S_IDLE, S_CHECK, S_PURGE, S_FILL, S_DONE} state_e;
  state_e state, stateNext;
  logic   aliasFlag;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    reqReady  = (state == S_IDLE);
    cmdValid  = (state == S_PURGE) || (state == S_FILL);
    cmdKind   = (state == S_PURGE) ? CMD_PURGE : CMD_FILL;
    doneValid = (state == S_DONE);
    case (state)
      S_IDLE: if (reqValid) begin
        strobe.latchReq = 1'b1;
        stateNext = S_CHECK;
      end
      S_CHECK: begin
        strobe.writeLine = !status.lineValid;
        if (status.lineValid && !(status.tagHit && status.vidxSame)) stateNext = S_PURGE;
        else stateNext = S_FILL;
      end
      S_PURGE: begin
        strobe.selOld    = 1'b1;
        strobe.writeLine = cmdReady;
        if (cmdReady) stateNext = S_FILL;
      end
      S_FILL: begin
        strobe.issueFill = 1'b1;
        if (cmdReady) stateNext = S_DONE;
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      aliasFlag <= 1'b0;
    end else begin
      state <= stateNext;
      if (state == S_CHECK) aliasFlag <= status.tagHit && !status.vidxSame;
    end
  end
  assign doneAlias = aliasFlag;

  // R7: a stalled command keeps its kind
  p_cmd_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !cmdReady) |=> cmdValid && $stable(cmdKind));
  // R7: an accepted purge is followed by a fill
  p_purge_then_fill_r7: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdReady && cmdKind == CMD_PURGE) |=> cmdValid && cmdKind == CMD_FILL);
  // R7: completion only right after an accepted fill
  p_done_after_fill_r7: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> $past(cmdValid && cmdReady && cmdKind == CMD_FILL));
  // R8: busy after accepting
  p_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);
endmodule

// File: rtl/alias_resolver.sv
module alias_resolver import ar_pkg::*; #(
  parameter int L1_SIZE_EXP  = 16,
  parameter int PAGE_EXP     = 12,
  parameter int L1_ASSOC_EXP = 1,
  parameter int LINE_W       = 10,
  parameter int L2_SET_W     = 3,
  localparam int VIDX_W      = L1_SIZE_EXP - PAGE_EXP - L1_ASSOC_EXP
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [LINE_W-1:0] reqLine,
  input  logic [VIDX_W-1:0] reqVidx,
  output logic              cmdValid,
  input  logic              cmdReady,
  output logic              cmdKind,
  output logic [LINE_W-1:0] cmdLine,
  output logic [VIDX_W-1:0] cmdVidx,
  output logic              doneValid,
  output logic              doneAlias
);
  arStrobe_t strobe;
  arStatus_t status;
  cmdKind_e  kindInt;

  ar_datapath #(.LINE_W(LINE_W), .SET_W(L2_SET_W), .VIDX_W(VIDX_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqLine(reqLine), .reqVidx(reqVidx),
    .status(status), .cmdLine(cmdLine), .cmdVidx(cmdVidx));

  ar_control uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .status(status), .strobe(strobe), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdKind(kindInt), .doneValid(doneValid), .doneAlias(doneAlias));

  assign cmdKind = kindInt;

  // R7: a stalled command keeps its address fields
  p_cmd_fields_r7: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !cmdReady) |=> $stable(cmdLine) && $stable(cmdVidx));
endmodule

// File: tb/tb_alias_resolver.sv
module tb_alias_resolver;
  localparam int LINE_W = 10;
  localparam int SET_W  = 3;
  localparam int VIDX_W = 3;
  localparam int TAG_W  = LINE_W - SET_W;
  localparam int SETS   = 1 << SET_W;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 1'b0, reqReady, cmdValid, cmdReady = 1'b0, cmdKind, doneValid, doneAlias;
  logic [LINE_W-1:0] reqLine = '0, cmdLine;
  logic [VIDX_W-1:0] reqVidx = '0, cmdVidx;

  always #2 clk = ~clk;

  alias_resolver dut (.clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqLine(reqLine), .reqVidx(reqVidx), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdKind(cmdKind), .cmdLine(cmdLine), .cmdVidx(cmdVidx), .doneValid(doneValid),
    .doneAlias(doneAlias));

  int nTests = 0, nFail = 0;
  bit refValid [SETS];
  logic [TAG_W-1:0]  refTag  [SETS];
  logic [VIDX_W-1:0] refVidx [SETS];

  task automatic chk(bit ok, string r, string what, int act, int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0d expected=%0d", r, what, act, exp);
    end
  endtask

  function automatic string classify(logic [LINE_W-1:0] ln, logic [VIDX_W-1:0] vx);
    logic [SET_W-1:0] s = ln[SET_W-1:0];
    if (!refValid[s]) return "R2";
    if (refTag[s] != ln[LINE_W-1:SET_W]) return "R6";
    return (refVidx[s] == vx) ? "R3" : "R4";
  endfunction

  task automatic runReq(logic [LINE_W-1:0] ln, logic [VIDX_W-1:0] vx, string force_tag);
    logic [SET_W-1:0] s = ln[SET_W-1:0];
    string r = (force_tag != "") ? force_tag : classify(ln, vx);
    int expN; bit expAlias;
    logic expK [2]; logic [LINE_W-1:0] expL [2]; logic [VIDX_W-1:0] expV [2];
    int got = 0; bit finished = 0; bit pend = 0; bit busyOk = 1; bit holdOk = 1;
    logic pK; logic [LINE_W-1:0] pL; logic [VIDX_W-1:0] pV;
    expAlias = refValid[s] && refTag[s] == ln[LINE_W-1:SET_W] && refVidx[s] != vx;
    if (refValid[s] && !(refTag[s] == ln[LINE_W-1:SET_W] && refVidx[s] == vx)) begin
      expN = 2; expK[0] = 1'b1; expL[0] = {refTag[s], s}; expV[0] = refVidx[s];
      expK[1] = 1'b0; expL[1] = ln; expV[1] = vx;
    end else begin
      expN = 1; expK[0] = 1'b0; expL[0] = ln; expV[0] = vx;
    end
    refValid[s] = 1; refTag[s] = ln[LINE_W-1:SET_W]; refVidx[s] = vx;

    @(negedge clk);
    chk(reqReady == 1'b1, "R8", "reqReady idle", int'(reqReady), 1);
    reqValid = 1'b1; reqLine = ln; reqVidx = vx;
    for (int cyc = 0; cyc < 300 && !finished; cyc++) begin
      @(negedge clk);
      reqValid = 1'b0;
      if (reqReady) busyOk = 0;
      if (doneValid) begin
        finished = 1;
        cmdReady = 1'b0;
      end else if (cmdValid) begin
        if (pend && (cmdKind != pK || cmdLine != pL || cmdVidx != pV)) holdOk = 0;
        cmdReady = 1'($urandom_range(0, 1));
        if (cmdReady) begin
          if (got < expN) begin
            chk(cmdKind == expK[got], r, "cmdKind", int'(cmdKind), int'(expK[got]));
            chk(cmdLine == expL[got], r, "cmdLine", int'(cmdLine), int'(expL[got]));
            chk(cmdVidx == expV[got], r, "cmdVidx", int'(cmdVidx), int'(expV[got]));
          end
          got++;
          pend = 0;
        end else begin
          pend = 1; pK = cmdKind; pL = cmdLine; pV = cmdVidx;
        end
      end else begin
        cmdReady = 1'b0;
      end
    end
    chk(finished, "R7", "completion seen", int'(finished), 1);
    chk(got == expN, r, "command count", got, expN);
    chk(doneAlias == expAlias, (expAlias ? "R4" : r), "doneAlias", int'(doneAlias), int'(expAlias));
    chk(holdOk, "R7", "stalled command held", int'(holdOk), 1);
    chk(busyOk, "R8", "reqReady low while busy", int'(busyOk), 1);
    @(negedge clk);
    chk(doneValid == 1'b0, "R7", "done single cycle", int'(doneValid), 0);
  endtask

  initial begin
    #(4 * 200000);
    nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < SETS; i++) begin refValid[i] = 0; refTag[i] = '0; refVidx[i] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady == 1'b1, "R1", "reqReady after reset", int'(reqReady), 1);
    chk(cmdValid == 1'b0, "R1", "cmdValid after reset", int'(cmdValid), 0);
    chk(doneValid == 1'b0, "R1", "doneValid after reset", int'(doneValid), 0);
    // directed corners
    runReq(10'h025, 3'd2, "R2");  // empty entry
    runReq(10'h025, 3'd2, "R3");  // same bits
    runReq(10'h025, 3'd6, "R4");  // alias
    runReq(10'h025, 3'd6, "R5");  // updated bits, no purge
    runReq(10'h06D, 3'd1, "R6");  // same set, other tag: victim purge
    runReq(10'h0F8, 3'd0, "R2");  // set 0 first use
    // random mix from a small tag pool
    for (int n = 0; n < 400; n++) begin
      logic [LINE_W-1:0] ln;
      ln = {TAG_W'($urandom_range(0, 3)), SET_W'($urandom_range(0, SETS - 1))};
      runReq(ln, VIDX_W'($urandom_range(0, (1 << VIDX_W) - 1)), "");
    end
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule